// File: doc/BRIEF.md
# PTP Event Frame Timestamp Qualifier

This block sits behind a receive header parser and decides, frame by frame, whether the timestamp latch of the port should capture the arrival time. For every received frame the parser presents the ethertype, an IP-present flag, the IP protocol, the UDP source and destination ports, the PTP version and the PTP message type, all marked by a one-cycle valid strobe. The block compares these fields with a small set of static configuration inputs: a receive enable, a mode, a one-bit message-type selector, a layer-2 match enable and a source-port check enable.

The layer-2 path looks for the PTP ethertype. The UDP path looks for UDP datagrams to the PTP event port. The mode then decides which of the two paths count, which PTP version is accepted and which message types are accepted. Only one message type can be chosen for the single-type modes, so a catch-all mode that accepts every frame is also provided. The result is a registered qualify pulse, one clock after the valid strobe.

Top module: `ptp_ts_qualifier`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `ts_qualify` is 0.
- R2: When `rx_en` is 0, no frame qualifies, whatever its fields or the mode.
- R3: In mode 0 (all frames), every frame strobed by `frm_valid` qualifies, whatever its header fields. A cycle with `frm_valid` low never produces a qualify pulse, in any mode.
- R4: A frame is a layer-2 PTP match when `l2_en` is 1 and its ethertype is 0x88F7. When `l2_en` is 0, no frame is a layer-2 match.
- R5: A frame is a UDP PTP match when `ip_present` is 1, the IP protocol is 17 and the UDP destination port is 319.
- R6: When `sport_chk_en` is 1, a UDP match also requires UDP source port 319. When it is 0, the source port is ignored.
- R7: In mode 1 (version 1 over UDP), a frame qualifies only if it is a UDP match, its PTP version is 1 and its message type equals the selected type. A layer-2 match alone does not qualify.
- R8: In mode 2 (one version-2 type), a frame qualifies if it is a layer-2 or a UDP match, its PTP version is 2 and its message type equals the selected type.
- R9: `msg_sel` = 0 selects Sync (message type 0). `msg_sel` = 1 selects Delay_Req (message type 1).
- R10: In mode 3 (version-2 events), a frame qualifies if it is a layer-2 or a UDP match, its PTP version is 2 and its message type is 0 to 3. Types 4 to 15 do not qualify.
- R11: `ts_qualify` rises in the cycle after the qualifying strobe and stays high for exactly one cycle for each qualifying frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive timestamp enable |
| mode | input | 2 | 0 all, 1 v1 over UDP, 2 one v2 type, 3 v2 events |
| msg_sel | input | 1 | 0 Sync, 1 Delay_Req |
| l2_en | input | 1 | Enable layer-2 ethertype match |
| sport_chk_en | input | 1 | Also require UDP source port 319 |
| frm_valid | input | 1 | Header fields valid strobe |
| ethertype | input | 16 | Frame ethertype |
| ip_present | input | 1 | Frame carries an IP header |
| ip_proto | input | 8 | IP protocol number |
| udp_sport | input | 16 | UDP source port |
| udp_dport | input | 16 | UDP destination port |
| ptp_ver | input | 4 | PTP version field |
| ptp_msg_type | input | 4 | PTP message type (low nibble of first header byte) |
| ts_qualify | output | 1 | One-cycle pulse: capture a timestamp for this frame |

## Verification
The only result is `ts_qualify`, and it is due exactly one rising edge after the cycle in which `frm_valid` is sampled high. The bench drives each frame on a falling edge and samples the output on the next falling edge, after one register stage. One cycle later it samples again to confirm that the pulse has ended. A back-to-back pair of a qualifying and a rejected frame shows that each result lands in its own cycle, with no carry-over from the frame before.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;
  typedef enum logic [1:0] {
    MODE_ALL      = 2'd0,
    MODE_V1_UDP   = 2'd1,
    MODE_V2_ONE   = 2'd2,
    MODE_V2_EVENT = 2'd3
  } ts_mode_e;

  localparam logic [3:0] MSG_SYNC      = 4'd0;
  localparam logic [3:0] MSG_DELAY_REQ = 4'd1;
  localparam logic [3:0] MSG_EVENT_MAX = 4'd3;
endpackage

// File: rtl/ptpc_l2_match.sv
module ptpc_l2_match #(
  parameter int          ETYPE_W   = 16,
  parameter logic [15:0] PTP_ETYPE = 16'h88F7
) (
  input  logic               l2_en,
  input  logic [ETYPE_W-1:0] ethertype,
  output logic               hit
);
  localparam logic [ETYPE_W-1:0] MATCH_VAL = ETYPE_W'(PTP_ETYPE);

  always_comb begin
    hit = l2_en && (ethertype == MATCH_VAL);
  end
endmodule

// File: rtl/ptpc_l4_match.sv
module ptpc_l4_match #(
  parameter int          PORT_W     = 16,
  parameter int          PROTO_W    = 8,
  parameter int          UDP_PROTO  = 17,
  parameter int          EVENT_PORT = 319
) (
  input  logic               ip_present,
  input  logic [PROTO_W-1:0] ip_proto,
  input  logic [PORT_W-1:0]  udp_sport,
  input  logic [PORT_W-1:0]  udp_dport,
  input  logic               sport_chk_en,
  output logic               hit
);
  localparam logic [PROTO_W-1:0] PROTO_VAL = PROTO_W'(UDP_PROTO);
  localparam logic [PORT_W-1:0]  PORT_VAL  = PORT_W'(EVENT_PORT);

  logic is_udp;
  logic dport_ok;
  logic sport_ok;

  always_comb begin
    is_udp   = ip_present && (ip_proto == PROTO_VAL);
    dport_ok = (udp_dport == PORT_VAL);
    sport_ok = !sport_chk_en || (udp_sport == PORT_VAL);
    hit      = is_udp && dport_ok && sport_ok;
  end
endmodule

// File: rtl/ptpc_msg_filter.sv
module ptpc_msg_filter
  import ptpc_pkg::*;
#(
  parameter int VER_W  = 4,
  parameter int TYPE_W = 4
) (
  input  ts_mode_e          mode,
  input  logic              msg_sel,
  input  logic [VER_W-1:0]  ptp_ver,
  input  logic [TYPE_W-1:0] ptp_msg_type,
  input  logic              l2_hit,
  input  logic              l4_hit,
  output logic              take
);
  localparam logic [VER_W-1:0]  VER1     = VER_W'(1);
  localparam logic [VER_W-1:0]  VER2     = VER_W'(2);
  localparam logic [TYPE_W-1:0] T_SYNC   = TYPE_W'(MSG_SYNC);
  localparam logic [TYPE_W-1:0] T_DREQ   = TYPE_W'(MSG_DELAY_REQ);
  localparam logic [TYPE_W-1:0] T_EVMAX  = TYPE_W'(MSG_EVENT_MAX);

  logic [TYPE_W-1:0] sel_type;
  logic              type_eq;
  logic              type_event;
  logic              any_hit;

  always_comb begin
    sel_type   = msg_sel ? T_DREQ : T_SYNC;
    type_eq    = (ptp_msg_type == sel_type);
    type_event = (ptp_msg_type <= T_EVMAX);
    any_hit    = l2_hit || l4_hit;
    unique case (mode)
      MODE_ALL:      take = 1'b1;
      MODE_V1_UDP:   take = l4_hit && (ptp_ver == VER1) && type_eq;
      MODE_V2_ONE:   take = any_hit && (ptp_ver == VER2) && type_eq;
      MODE_V2_EVENT: take = any_hit && (ptp_ver == VER2) && type_event;
      default:       take = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptp_ts_qualifier.sv
module ptp_ts_qualifier
  import ptpc_pkg::*;
#(
  parameter int ETYPE_W = 16,
  parameter int PROTO_W = 8,
  parameter int PORT_W  = 16,
  parameter int VER_W   = 4,
  parameter int TYPE_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_en,
  input  logic [1:0]         mode,
  input  logic               msg_sel,
  input  logic               l2_en,
  input  logic               sport_chk_en,
  input  logic               frm_valid,
  input  logic [ETYPE_W-1:0] ethertype,
  input  logic               ip_present,
  input  logic [PROTO_W-1:0] ip_proto,
  input  logic [PORT_W-1:0]  udp_sport,
  input  logic [PORT_W-1:0]  udp_dport,
  input  logic [VER_W-1:0]   ptp_ver,
  input  logic [TYPE_W-1:0]  ptp_msg_type,
  output logic               ts_qualify
);
  ts_mode_e mode_e;
  logic     l2_hit;
  logic     l4_hit;
  logic     take;
  logic     qual_d;
  logic     qual_q;

  assign mode_e = ts_mode_e'(mode);

  ptpc_l2_match #(.ETYPE_W(ETYPE_W)) u_l2 (
    .l2_en     (l2_en),
    .ethertype (ethertype),
    .hit       (l2_hit)
  );

  ptpc_l4_match #(.PORT_W(PORT_W), .PROTO_W(PROTO_W)) u_l4 (
    .ip_present   (ip_present),
    .ip_proto     (ip_proto),
    .udp_sport    (udp_sport),
    .udp_dport    (udp_dport),
    .sport_chk_en (sport_chk_en),
    .hit          (l4_hit)
  );

  ptpc_msg_filter #(.VER_W(VER_W), .TYPE_W(TYPE_W)) u_filt (
    .mode         (mode_e),
    .msg_sel      (msg_sel),
    .ptp_ver      (ptp_ver),
    .ptp_msg_type (ptp_msg_type),
    .l2_hit       (l2_hit),
    .l4_hit       (l4_hit),
    .take         (take)
  );

  // next state
  always_comb begin
    qual_d = frm_valid && rx_en && take;
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qual_q <= 1'b0;
    else        qual_q <= qual_d;
  end

  assign ts_qualify = qual_q;

  // R2
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !ts_qualify);

  // R3
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !ts_qualify);

  // R3
  all_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && rx_en && mode == 2'd0) |=> ts_qualify);

  // R7
  v1_version_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && ptp_ver != VER_W'(1)) |=> !ts_qualify);

  // R10
  v2_event_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && ptp_msg_type > TYPE_W'(3)) |=> !ts_qualify);

  // R6
  sport_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && sport_chk_en && udp_sport != PORT_W'(319)) |=> !ts_qualify);
endmodule

// File: tb/ptp_ts_qualifier_bench.sv
module ptp_ts_qualifier_bench;
  logic        clk;
  logic        rst_n;
  logic        rx_en;
  logic [1:0]  mode;
  logic        msg_sel;
  logic        l2_en;
  logic        sport_chk_en;
  logic        frm_valid;
  logic [15:0] ethertype;
  logic        ip_present;
  logic [7:0]  ip_proto;
  logic [15:0] udp_sport;
  logic [15:0] udp_dport;
  logic [3:0]  ptp_ver;
  logic [3:0]  ptp_msg_type;
  logic        ts_qualify;

  int n_tests;
  int n_fail;
  bit done;

  ptp_ts_qualifier u_ptp_ts_qualifier (
    .clk (clk), .rst_n (rst_n), .rx_en (rx_en), .mode (mode),
    .msg_sel (msg_sel), .l2_en (l2_en), .sport_chk_en (sport_chk_en),
    .frm_valid (frm_valid), .ethertype (ethertype), .ip_present (ip_present),
    .ip_proto (ip_proto), .udp_sport (udp_sport), .udp_dport (udp_dport),
    .ptp_ver (ptp_ver), .ptp_msg_type (ptp_msg_type), .ts_qualify (ts_qualify)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ts_qualify=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic en, input logic [1:0] m, input logic sel,
                     input logic l2, input logic sp);
    @(negedge clk);
    rx_en = en; mode = m; msg_sel = sel; l2_en = l2; sport_chk_en = sp;
  endtask

  // One frame: strobe on a falling edge, result after one rising edge,
  // then confirm the pulse is gone one cycle later.
  task automatic frame(input logic [15:0] et, input logic ipp, input logic [7:0] pr,
                       input logic [15:0] sp, input logic [15:0] dp,
                       input logic [3:0] ver, input logic [3:0] mt,
                       input logic exp, input string tag);
    @(negedge clk);
    frm_valid = 1'b1; ethertype = et; ip_present = ipp; ip_proto = pr;
    udp_sport = sp; udp_dport = dp; ptp_ver = ver; ptp_msg_type = mt;
    @(negedge clk);
    frm_valid = 1'b0;
    check(ts_qualify, exp, tag);
    @(negedge clk);
    check(ts_qualify, 1'b0, {tag, " R11 pulse end"});
  endtask

  task automatic t_reset;
    rst_n = 1'b0; frm_valid = 1'b0; rx_en = 1'b1; mode = 2'd0; msg_sel = 1'b0;
    l2_en = 1'b1; sport_chk_en = 1'b0; ethertype = 16'h0; ip_present = 1'b0;
    ip_proto = 8'd0; udp_sport = 16'd0; udp_dport = 16'd0; ptp_ver = 4'd0;
    ptp_msg_type = 4'd0;
    repeat (3) @(negedge clk);
    check(ts_qualify, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(ts_qualify, 1'b0, "R1 after release");
  endtask

  task automatic t_disabled;
    cfg(1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
    frame(16'h88F7, 1'b0, 8'd0, 16'd0, 16'd0, 4'd2, 4'd0, 1'b0, "R2 all mode off");
    cfg(1'b0, 2'd3, 1'b0, 1'b1, 1'b0);
    frame(16'h0800, 1'b1, 8'd17, 16'd319, 16'd319, 4'd2, 4'd1, 1'b0, "R2 v2 udp off");
  endtask

  task automatic t_all;
    cfg(1'b1, 2'd0, 1'b0, 1'b0, 1'b1);
    frame(16'h0806, 1'b0, 8'd6, 16'd1, 16'd2, 4'd9, 4'd15, 1'b1, "R3 arbitrary frame");
    frame(16'h0800, 1'b1, 8'd17, 16'd5, 16'd320, 4'd1, 4'd8, 1'b1, "R3 non-ptp udp");
    @(negedge clk);
    check(ts_qualify, 1'b0, "R3 no strobe");
  endtask

  task automatic t_l2;
    cfg(1'b1, 2'd3, 1'b0, 1'b1, 1'b0);
    frame(16'h88F7, 1'b0, 8'd0, 16'd0, 16'd0, 4'd2, 4'd2, 1'b1, "R4 l2 ethertype");
    frame(16'h88F8, 1'b0, 8'd0, 16'd0, 16'd0, 4'd2, 4'd2, 1'b0, "R4 wrong ethertype");
    cfg(1'b1, 2'd3, 1'b0, 1'b0, 1'b0);
    frame(16'h88F7, 1'b0, 8'd0, 16'd0, 16'd0, 4'd2, 4'd2, 1'b0, "R4 l2 disabled");
  endtask

  task automatic t_l4;
    cfg(1'b1, 2'd3, 1'b0, 1'b0, 1'b0);
    frame(16'h0800, 1'b1, 8'd17, 16'd1234, 16'd319, 4'd2, 4'd0, 1'b1, "R5 udp 319, R6 sport ignored");
    frame(16'h0800, 1'b1, 8'd6, 16'd319, 16'd319, 4'd2, 4'd0, 1'b0, "R5 tcp rejected");
    frame(16'h0800, 1'b1, 8'd17, 16'd319, 16'd320, 4'd2, 4'd0, 1'b0, "R5 port 320 rejected");
    frame(16'h0800, 1'b0, 8'd17, 16'd319, 16'd319, 4'd2, 4'd0, 1'b0, "R5 no ip header");
    cfg(1'b1, 2'd3, 1'b0, 1'b0, 1'b1);
    frame(16'h0800, 1'b1, 8'd17, 16'd1234, 16'd319, 4'd2, 4'd0, 1'b0, "R6 sport mismatch");
    frame(16'h0800, 1'b1, 8'd17, 16'd319, 16'd319, 4'd2, 4'd0, 1'b1, "R6 sport match");
  endtask

  task automatic t_v1;
    cfg(1'b1, 2'd1, 1'b0, 1'b1, 1'b0);
    frame(16'h0800, 1'b1, 8'd17, 16'd319, 16'd319, 4'd1, 4'd0, 1'b1, "R7 v1 sync udp");
    frame(16'h0800, 1'b1, 8'd17, 16'd319, 16'd319, 4'd2, 4'd0, 1'b0, "R7 v2 rejected");
    frame(16'h88F7, 1'b0, 8'd0, 16'd0, 16'd0, 4'd1, 4'd0, 1'b0, "R7 l2 not accepted");
    frame(16'h0800, 1'b1, 8'd17, 16'd319, 16'd319, 4'd1, 4'd1, 1'b0, "R9 v1 delay_req with sync sel");
    cfg(1'b1, 2'd1, 1'b1, 1'b1, 1'b0);
    frame(16'h0800, 1'b1, 8'd17, 16'd319, 16'd319, 4'd1, 4'd1, 1'b1, "R9 v1 delay_req sel");
  endtask

  task automatic t_v2_one;
    cfg(1'b1, 2'd2, 1'b0, 1'b1, 1'b0);
    frame(16'h88F7, 1'b0, 8'd0, 16'd0, 16'd0, 4'd2, 4'd0, 1'b1, "R8 l2 sync");
    frame(16'h0800, 1'b1, 8'd17, 16'd9, 16'd319, 4'd2, 4'd0, 1'b1, "R8 udp sync");
    frame(16'h88F7, 1'b0, 8'd0, 16'd0, 16'd0, 4'd2, 4'd1, 1'b0, "R8 delay_req rejected");
    frame(16'h88F7, 1'b0, 8'd0, 16'd0, 16'd0, 4'd1, 4'd0, 1'b0, "R8 v1 rejected");
    cfg(1'b1, 2'd2, 1'b1, 1'b1, 1'b0);
    frame(16'h88F7, 1'b0, 8'd0, 16'd0, 16'd0, 4'd2, 4'd1, 1'b1, "R9 v2 delay_req sel");
    frame(16'h88F7, 1'b0, 8'd0, 16'd0, 16'd0, 4'd2, 4'd0, 1'b0, "R9 sync with delay_req sel");
  endtask

  task automatic t_v2_event;
    cfg(1'b1, 2'd3, 1'b1, 1'b1, 1'b0);
    frame(16'h88F7, 1'b0, 8'd0, 16'd0, 16'd0, 4'd2, 4'd3, 1'b1, "R10 type 3");
    frame(16'h88F7, 1'b0, 8'd0, 16'd0, 16'd0, 4'd2, 4'd4, 1'b0, "R10 type 4");
    frame(16'h0800, 1'b1, 8'd17, 16'd0, 16'd319, 4'd2, 4'd0, 1'b1, "R10 udp type 0");
    frame(16'h88F7, 1'b0, 8'd0, 16'd0, 16'd0, 4'd2, 4'd11, 1'b0, "R10 type 11");
  endtask

  task automatic t_back_to_back;
    cfg(1'b1, 2'd3, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    frm_valid = 1'b1; ethertype = 16'h88F7; ptp_ver = 4'd2; ptp_msg_type = 4'd1;
    @(negedge clk);
    check(ts_qualify, 1'b1, "R11 first of pair");
    ptp_msg_type = 4'd12;
    @(negedge clk);
    frm_valid = 1'b0;
    check(ts_qualify, 1'b0, "R11 second of pair");
    @(negedge clk);
    check(ts_qualify, 1'b0, "R11 idle after pair");
  endtask

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    t_reset();
    t_disabled();
    t_all();
    t_l2();
    t_l4();
    t_v1();
    t_v2_one();
    t_v2_event();
    t_back_to_back();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule